// File: doc/BRIEF.md
# Write-Protected System Clock Control Register

This block holds the eight-bit control word that steers a small microcontroller's system clock. Software writes it over a byte-wide port. A write lands only while an external unlock input is high. Three lock inputs then decide, bit by bit, which parts of the write may change the stored value:

- clock-change freeze,
- watchdog clock guard,
- oscillation-stop monitor enable.

Bits that a lock refuses keep their old value, and nothing reports the refusal.

The stored word drives several outputs:

- a single-cycle stop-mode request pulse,
- a main/PLL source select, which an external override input can force back to main,
- three oscillator trim outputs,
- a main-clock divider, which emits a one-cycle clock-enable pulse every 1, 2, 4 or 16 cycles.

A change to the divider field takes effect only at the end of the period already running. As a result, no shortened enable interval ever appears. The stored word can always be read back.

Top module: `sysclk_ctl`

## Requirements
- R1: With reset held (synchronous, active low) the stored word becomes 0x20. After release `rd_data` reads 0x20, `stop_pulse` is 0 and the divider runs at divide-by-1.
- R2: When `wr_unlock` is 0, a write (`wr_en`=1) changes no bit of the stored word.
- R3: Bit 2 is reserved and always reads 0, whatever is written.
- R4: While `chg_lock` is 1, a write leaves bits 0 and 1 unchanged and still updates bits 3 to 7.
- R5: While `wdt_guard` is 1, a write leaves bit 0 unchanged.
- R6: A write that would set bit 0 to 1 leaves bit 0 unchanged in three cases: stored bit 1 is 1, the same write sets bit 1, or `osd_en` is 1.
- R7: Each write that sets bit 0 to 1 and is accepted raises `stop_pulse` for exactly one cycle, in the cycle the new value appears. Bit 0 then reads 1 until it is written 0 or reset.
- R8: `pll_sel` is 1 only when stored bit 1 is 1 and `src_override` is 0.
- R9: `fb_res_off`, `lsosc_off` and `drive_high` follow stored bits 3, 4 and 5.
- R10: Bits 7:6 select the divide ratio of `div_tick`: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 16. `div_tick` is high for one cycle in each period.
- R11: A new divider code is adopted only at the cycle in which `div_tick` is high. The period already running completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data |
| wr_unlock | input | 1 | Write permission; writes dropped when 0 |
| chg_lock | input | 1 | Clock-change freeze; protects bits 0 and 1 |
| wdt_guard | input | 1 | Watchdog clock guard; protects bit 0 |
| osd_en | input | 1 | Oscillation-stop monitor enabled; blocks setting bit 0 |
| src_override | input | 1 | Forces the source select output to main when 1 |
| rd_data | output | 8 | Stored control word |
| stop_pulse | output | 1 | One-cycle stop-mode request |
| pll_sel | output | 1 | Source select: 1 means PLL |
| fb_res_off | output | 1 | Oscillator feedback resistor disconnected |
| lsosc_off | output | 1 | Low-speed internal oscillator off |
| drive_high | output | 1 | Oscillator high drive strength |
| div_tick | output | 1 | Divided main-clock enable pulse |

## Verification
The bench goes after the lock interactions where a per-bit mask is easy to get wrong. One case is a single write that sets bits 0 and 1 together. A design that checks only the stored source bit would enter stop mode with the PLL selected. Another is a write under the clock-change freeze. A design that blocks the whole write would lose the divider and trim bits. The bench also changes the divide code in the middle of a long period. A design that reloads at once would emit a short period. Finally, the bench drives random mixes of locks and data against a behavioural model, to catch stray stop pulses or a reserved bit that sticks at 1.

// File: rtl/sysclk_pkg.sv
// Package: shared constants and helpers for the clock control register.
// Assumes an 8-bit control word with fixed field positions that the
// divider and the oscillator outputs decode.
package sysclk_pkg;
    parameter int unsigned CTRL_W = 8;
    parameter int unsigned DIV_W  = 4;
    parameter int unsigned CODE_W = 2;

    localparam int unsigned STOP_BIT = 0;
    localparam int unsigned SRC_BIT  = 1;
    localparam int unsigned RSV_BIT  = 2;
    localparam int unsigned FBR_BIT  = 3;
    localparam int unsigned LSO_BIT  = 4;
    localparam int unsigned DRV_BIT  = 5;
    localparam int unsigned DIV_LO   = 6;

    // Terminal count (ratio minus one) for each divider code.
    function automatic logic [DIV_W-1:0] div_last(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            2'b00:   r = DIV_W'(0);
            2'b01:   r = DIV_W'(1);
            2'b10:   r = DIV_W'(3);
            default: r = DIV_W'(15);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sysclk_wr_gate.sv
// Module: per-bit write acceptance mask.
// Decides which bits of an incoming write may change the stored word.
// Assumes the lock inputs are already synchronous to clk.
module sysclk_wr_gate
    import sysclk_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_unlock,
    input  logic              chg_lock,
    input  logic              wdt_guard,
    input  logic              osd_en,
    input  logic              cur_src,
    input  logic [1:0]        new_low,
    output logic [CTRL_W-1:0] bit_we
);
    logic base_ok;
    logic stop_forbid;

    // Purpose: build the enable for every bit from the lock conditions.
    always_comb begin
        base_ok     = wr_en && wr_unlock;
        stop_forbid = new_low[0] && (cur_src || new_low[1] || osd_en);
        bit_we      = '0;
        for (int b = 0; b < int'(CTRL_W); b++) begin
            bit_we[b] = base_ok;
        end
        bit_we[RSV_BIT]  = 1'b0;
        bit_we[SRC_BIT]  = base_ok && !chg_lock;
        bit_we[STOP_BIT] = base_ok && !chg_lock && !wdt_guard && !stop_forbid;
    end
endmodule

// File: rtl/sysclk_store.sv
// Module: storage for the control word plus the stop request pulse.
// Each bit loads only when its enable is set; the reserved bit is a
// constant zero. Assumes synchronous active-low reset.
module sysclk_store
    import sysclk_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RST_VAL = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] bit_we,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] word,
    output logic              stop_pulse
);
    genvar gi;
    generate
        for (gi = 0; gi < int'(CTRL_W); gi++) begin : g_bit
            if (gi == int'(RSV_BIT)) begin : g_rsv
                assign word[gi] = 1'b0;
            end else begin : g_ff
                logic q;
                // Purpose: hold one control bit, load it when enabled.
                always_ff @(posedge clk) begin
                    if (!rst_n)          q <= RST_VAL[gi];
                    else if (bit_we[gi]) q <= wr_data[gi];
                end
                assign word[gi] = q;
            end
        end
    endgenerate

    // Purpose: one-cycle stop request for each accepted write of bit 0 = 1.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_pulse <= 1'b0;
        else        stop_pulse <= bit_we[STOP_BIT] && wr_data[STOP_BIT];
    end
endmodule

// File: rtl/sysclk_div.sv
// Module: main-clock divider producing a one-cycle enable every N cycles.
// The code is sampled only at terminal count so periods never shorten.
module sysclk_div
    import sysclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [DIV_W-1:0]  cnt;
    logic [CODE_W-1:0] act_code;

    // Purpose: terminal-count detect for the ratio in force.
    always_comb tick = (cnt == div_last(act_code));

    // Purpose: advance the count, wrap and adopt a new code at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_code <= '0;
        end else if (tick) begin
            cnt      <= '0;
            act_code <= code;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sysclk_ctl.sv
// Module: write-protected system clock control register (top).
// Combines the write gate, the storage and the divider, and decodes the
// stored word into clock controls. Assumes all inputs are synchronous.
module sysclk_ctl
    import sysclk_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_unlock,
    input  logic       chg_lock,
    input  logic       wdt_guard,
    input  logic       osd_en,
    input  logic       src_override,
    output logic [7:0] rd_data,
    output logic       stop_pulse,
    output logic       pll_sel,
    output logic       fb_res_off,
    output logic       lsosc_off,
    output logic       drive_high,
    output logic       div_tick
);
    logic [CTRL_W-1:0] bit_we;
    logic [CTRL_W-1:0] word;

    sysclk_wr_gate u_gate (
        .wr_en     (wr_en),
        .wr_unlock (wr_unlock),
        .chg_lock  (chg_lock),
        .wdt_guard (wdt_guard),
        .osd_en    (osd_en),
        .cur_src   (word[SRC_BIT]),
        .new_low   (wr_data[1:0]),
        .bit_we    (bit_we)
    );

    sysclk_store #(.RST_VAL(RST_VAL)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_we     (bit_we),
        .wr_data    (wr_data),
        .word       (word),
        .stop_pulse (stop_pulse)
    );

    sysclk_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (word[DIV_LO +: CODE_W]),
        .tick  (div_tick)
    );

    // Purpose: decode the stored word into clock control outputs.
    always_comb begin
        rd_data    = word;
        pll_sel    = word[SRC_BIT] && !src_override;
        fb_res_off = word[FBR_BIT];
        lsosc_off  = word[LSO_BIT];
        drive_high = word[DRV_BIT];
    end
endmodule

// File: rtl/sysclk_ctl_chk.sv
// Module: assertion checker bound to sysclk_ctl; observes ports only.
module sysclk_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       wr_unlock,
    input logic       chg_lock,
    input logic       wdt_guard,
    input logic       osd_en,
    input logic       src_override,
    input logic [7:0] rd_data,
    input logic       stop_pulse,
    input logic       pll_sel,
    input logic       fb_res_off,
    input logic       lsosc_off,
    input logic       drive_high,
    input logic       div_tick
);
    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] == 1'b0);

    // R2
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_unlock |=> $stable(rd_data));

    // R4
    chg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_lock |=> $stable(rd_data[1:0]));

    // R5
    wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_guard |=> $stable(rd_data[0]));

    // R6
    stop_forbid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> (!$past(osd_en) && !$past(rd_data[1]) && !$past(wr_data[1])));

    // R7
    stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (rd_data[0] && $past(wr_en && wr_unlock && wr_data[0])));

    // R8
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_override |-> !pll_sel);

    // R9
    osc_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_high) |-> $past(wr_data[5] && wr_en && wr_unlock));

    logic unused_ok;
    always_comb unused_ok = fb_res_off ^ lsosc_off ^ div_tick;
endmodule

bind sysclk_ctl sysclk_ctl_chk chk_i (.*);

// File: tb/sysclk_ctl_tb_top.sv
module sysclk_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_unlock = 1'b0;
    logic       chg_lock = 1'b0;
    logic       wdt_guard = 1'b0;
    logic       osd_en = 1'b0;
    logic       src_override = 1'b0;
    logic [7:0] rd_data;
    logic       stop_pulse, pll_sel, fb_res_off, lsosc_off, drive_high, div_tick;

    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // behavioural reference state
    logic [7:0] m_reg = 8'h20;
    bit         m_stop = 1'b0;
    int         m_ph = 0;
    int         m_act = 0;

    always #2 clk = ~clk;

    sysclk_ctl dut_i (.*);

    function automatic int ratio(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input string t, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // reference model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 8'h20; m_stop = 0; m_ph = 0; m_act = 0;
        end else begin
            logic [7:0] nb;
            if (m_ph == ratio(m_act) - 1) begin
                m_ph = 0; m_act = int'(m_reg[7:6]);
            end else m_ph++;
            m_stop = 0;
            if (wr_en && wr_unlock) begin
                nb = m_reg;
                nb[7:3] = wr_data[7:3];
                if (!chg_lock) nb[1] = wr_data[1];
                if (!chg_lock && !wdt_guard &&
                    !(wr_data[0] && (m_reg[1] || wr_data[1] || osd_en))) begin
                    nb[0] = wr_data[0];
                    m_stop = wr_data[0];
                end
                m_reg = nb;
            end
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({tag, " rd_data"}, rd_data, m_reg);
            chk({tag, " stop_pulse R7"}, stop_pulse, m_stop);
            chk({tag, " pll_sel R8"}, pll_sel, m_reg[1] && !src_override);
            chk({tag, " osc R9"}, {fb_res_off, lsosc_off, drive_high}, {m_reg[3], m_reg[4], m_reg[5]});
            chk({tag, " div_tick R10"}, div_tick, m_ph == ratio(m_act) - 1);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        int cnt;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        tag = "R1";
        chk("R1 reset word", rd_data, 8'h20);
        chk("R1 stop idle", stop_pulse, 0);
        chk("R1 div1 tick", div_tick, 1);

        tag = "R2";
        wr_unlock = 0;
        wr(8'hFF);
        @(negedge clk) chk("R2 locked write dropped", rd_data, 8'h20);

        tag = "R3";
        wr_unlock = 1;
        wr(8'h3C);
        @(negedge clk) chk("R3 reserved bit reads 0", rd_data, 8'h38);
        chk("R9 trim outputs", {fb_res_off, lsosc_off, drive_high}, 3'b111);

        tag = "R4";
        chg_lock = 1;
        wr(8'hC2);
        @(negedge clk) chk("R4 bits1:0 frozen, 7:3 loaded", rd_data, 8'hC0);
        chg_lock = 0;
        wr(8'h00);

        tag = "R5";
        wdt_guard = 1;
        wr(8'h01);
        @(negedge clk) chk("R5 bit0 held", rd_data[0], 0);
        chk("R5 no stop pulse", stop_pulse, 0);
        wdt_guard = 0;

        tag = "R6";
        wr(8'h03);
        @(negedge clk) chk("R6 stop blocked by same-write pll", rd_data, 8'h02);
        wr(8'h03);
        @(negedge clk) chk("R6 stop blocked by stored pll", rd_data, 8'h02);
        wr(8'h00);
        osd_en = 1;
        wr(8'h01);
        @(negedge clk) chk("R6 stop blocked by osd", rd_data[0], 0);
        osd_en = 0;

        tag = "R8";
        wr(8'h02);
        @(negedge clk) chk("R8 pll selected", pll_sel, 1);
        #1 src_override = 1;
        @(negedge clk) chk("R8 override forces main", pll_sel, 0);
        #1 src_override = 0;
        wr(8'h00);

        tag = "R7";
        wr(8'h01);
        @(negedge clk) chk("R7 pulse high", stop_pulse, 1);
        chk("R7 bit0 set", rd_data[0], 1);
        @(negedge clk) chk("R7 pulse one cycle", stop_pulse, 0);
        chk("R7 bit0 sticky", rd_data[0], 1);
        wr(8'h00);
        @(negedge clk) chk("R7 bit0 cleared", rd_data[0], 0);

        tag = "R10";
        wr(8'hC0);
        idle(20);
        cnt = 0;
        for (int i = 0; i < 32; i++) begin @(negedge clk); cnt += div_tick; end
        chk("R10 div16 ticks in 32", cnt, 2);
        wr(8'h80);
        idle(20);
        cnt = 0;
        for (int i = 0; i < 32; i++) begin @(negedge clk); cnt += div_tick; end
        chk("R10 div4 ticks in 32", cnt, 8);
        wr(8'h40);
        idle(8);

        tag = "R11";
        wr(8'hC0);
        do @(negedge clk); while (div_tick !== 1'b1);
        @(negedge clk);
        do @(negedge clk); while (div_tick !== 1'b1);
        @(posedge clk); #1;
        wr_en = 1; wr_data = 8'h00;
        cnt = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk); cnt += div_tick;
            if (i == 0) begin @(posedge clk); #1 wr_en = 0; end
        end
        chk("R11 old period completes", cnt, 0);
        @(negedge clk) chk("R11 terminal tick", div_tick, 1);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); cnt += div_tick; end
        chk("R11 new ratio adopted", cnt, 5);

        tag = "R6 random";
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            wr_en        = ($urandom_range(0, 1) == 1);
            wr_data      = 8'($urandom_range(0, 255));
            wr_unlock    = ($urandom_range(0, 3) != 0);
            chg_lock     = ($urandom_range(0, 3) == 0);
            wdt_guard    = ($urandom_range(0, 3) == 0);
            osd_en       = ($urandom_range(0, 3) == 0);
            src_override = ($urandom_range(0, 3) == 0);
        end
        @(posedge clk); #1;
        wr_en = 0;
        idle(4);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule